// File: doc/BRIEF.md
# Per-Core Two-Stage Tick Timer

This block is one local timer of the kind placed once per processor core, each copy answering at its own window in a shared register space. A prescaler divides the input clock by a programmable amount. Every prescaler underflow steps a second down-counter that holds the interrupt period. When that counter runs out, an interrupt status flag is raised. In interval mode the counter reloads and keeps firing. In one-shot mode it parks at zero.

Software programs the prescaler reload and the committed interrupt period. It then sets the two start bits, and optionally the interval bit, in the control register. A new period only takes effect when the write carries the update-request bit. Every write to a timing register leaves a sticky flag in a write-status register, which software polls and then clears. The interrupt line is the status flag gated by an enable bit.

Top module: `core_tick_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The block answers only in the 256-byte window at 0x300 + 0x100*INST_ID. Offsets are 0x00 prescaler reload, 0x08 interrupt count, 0x20 control, 0x30 status, 0x34 enable and 0x40 write status. An access outside the window reads 0 and changes no register.
- R3: Control bit 0 runs the prescaler, bit 1 runs the interrupt counter and bit 2 selects interval mode. With prescaler reload N and committed count M, status first sets M*(N+1) clocks after the edge that writes the start bits.
- R4: A write to offset 0x08 with bit 31 set commits bits 30:0 and loads them into the running counter on the following clock. A write with bit 31 clear changes nothing. Bit 31 always reads back as 0.
- R5: In one-shot mode (bit 2 clear) the counter stops at zero after it expires, and status does not set again.
- R6: In interval mode the counter reloads the committed count on expiry, so status sets again every M*(N+1) clocks.
- R7: Status is bit 0 of offset 0x30. Writing 1 to it clears the flag; writing 0 leaves it alone. A new expiry on the same edge wins over a clear.
- R8: `irq_o` is high exactly when status is set and enable (bit 0 of offset 0x34) is set.
- R9: Write status at offset 0x40 sets bit 0 after a prescaler-reload write, bit 1 after an interrupt-count write and bit 3 after a control write. Each bit clears when 1 is written to it.
- R10: With both start bits clear, the timer makes no progress and status does not set.
- R11: A prescaler reload of 0 steps the interrupt counter on every clock, so status sets M clocks after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while a read is requested |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench measures the clock count to the first expiry for several prescaler settings, including a reload of 0. A design that is off by one in the prescaler, or that reloads it late, shows up as a count of M*N or M*(N+2) instead of M*(N+1). In interval mode the bench clears the flag after each firing and checks that later firings land on exact multiples of the period; a design that reloads from the wrong value, or loses the flag to the clear, breaks that spacing. It also checks that an uncommitted count write is ignored, that a foreign instance's window leaves the registers untouched, that writing 0 does not clear the status flag, and that a one-shot timer stays silent after it fires.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam logic [7:0] OFS_TCNT = 8'h00;
  localparam logic [7:0] OFS_ICNT = 8'h08;
  localparam logic [7:0] OFS_CTRL = 8'h20;
  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_IEN  = 8'h34;
  localparam logic [7:0] OFS_WST  = 8'h40;

  localparam int unsigned WST_TCNT = 0;
  localparam int unsigned WST_ICNT = 1;
  localparam int unsigned WST_CTRL = 3;
  localparam int unsigned WST_W    = 4;

  localparam int unsigned UPD_BIT  = 31;

  typedef struct packed {
    logic interval;
    logic int_run;
    logic tick_run;
  } ctrl_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned TICK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [TICK_W-1:0] reload_i,
  output logic              tick_o
);

  logic [TICK_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= reload_i;
    else                         cnt_q <= cnt_q - 1'b1;
  end

  // R3: a running prescaler steps down by exactly one per clock
  a_r3_presc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/int_counter.sv
module int_counter #(
  parameter int unsigned ICNT_W = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              interval_i,
  input  logic              load_i,
  input  logic [ICNT_W-1:0] commit_i,
  output logic              expire_o
);

  localparam logic [ICNT_W-1:0] ONE = ICNT_W'(1);

  logic [ICNT_W-1:0] cnt_q;
  logic              step;

  assign step     = tick_i && run_i && !load_i && (cnt_q != '0);
  assign expire_o = step && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_i)    cnt_q <= commit_i;
    else if (expire_o)  cnt_q <= interval_i ? commit_i : '0;
    else if (step)      cnt_q <= cnt_q - 1'b1;
  end

  // R5: one-shot expiry parks the counter at zero
  a_r5_oneshot_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !interval_i) |=> (cnt_q == '0));

  // R6: interval expiry restarts from the committed count
  a_r6_interval_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && interval_i) |=> (cnt_q == $past(commit_i)));

  // R4: committed count lands in the counter one clock after the request
  a_r4_load_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(commit_i)));

endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned INST_ID = 0,
  parameter int unsigned TICK_W  = 32,
  parameter int unsigned ICNT_W  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              expire_i,
  output logic [TICK_W-1:0] tcnt_o,
  output logic [ICNT_W-1:0] commit_o,
  output logic              load_o,
  output ctrl_t             ctrl_o,
  output logic              status_o,
  output logic              ien_o
);

  localparam logic [31:0] BASE_ADDR = 32'h300 + 32'h100 * INST_ID;
  localparam logic [ADDR_W-9:0] BLK = BASE_ADDR[ADDR_W-1:8];

  logic              hit, wr, rd;
  logic [7:0]        ofs;
  logic              wr_tcnt, wr_icnt, wr_ctrl, wr_stat, wr_ien, wr_wst;
  logic [TICK_W-1:0] tcnt_q;
  logic [ICNT_W-1:0] commit_q;
  logic              load_q;
  ctrl_t             ctrl_q;
  logic              status_q, ien_q;
  logic [WST_W-1:0]  wst_q, wst_set;
  logic [31:0]       rmux;

  assign hit = req_i && (addr_i[ADDR_W-1:8] == BLK);
  assign ofs = addr_i[7:0];
  assign wr  = hit && we_i;
  assign rd  = hit && !we_i;

  assign wr_tcnt = wr && (ofs == OFS_TCNT);
  assign wr_icnt = wr && (ofs == OFS_ICNT);
  assign wr_ctrl = wr && (ofs == OFS_CTRL);
  assign wr_stat = wr && (ofs == OFS_STAT);
  assign wr_ien  = wr && (ofs == OFS_IEN);
  assign wr_wst  = wr && (ofs == OFS_WST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q   <= '0;
      commit_q <= '0;
      load_q   <= 1'b0;
      ctrl_q   <= '0;
      ien_q    <= 1'b0;
    end else begin
      load_q <= wr_icnt && wdata_i[UPD_BIT];
      if (wr_tcnt)                     tcnt_q   <= wdata_i[TICK_W-1:0];
      if (wr_icnt && wdata_i[UPD_BIT]) commit_q <= wdata_i[ICNT_W-1:0];
      if (wr_ctrl)                     ctrl_q   <= ctrl_t'(wdata_i[2:0]);
      if (wr_ien)                      ien_q    <= wdata_i[0];
    end
  end

  // expiry outranks a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    status_q <= 1'b0;
    else if (expire_i)              status_q <= 1'b1;
    else if (wr_stat && wdata_i[0]) status_q <= 1'b0;
  end

  always_comb begin
    wst_set           = '0;
    wst_set[WST_TCNT] = wr_tcnt;
    wst_set[WST_ICNT] = wr_icnt;
    wst_set[WST_CTRL] = wr_ctrl;
  end

  for (genvar i = 0; i < WST_W; i++) begin : g_wst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    wst_q[i] <= 1'b0;
      else if (wst_set[i])            wst_q[i] <= 1'b1;
      else if (wr_wst && wdata_i[i])  wst_q[i] <= 1'b0;
    end
  end

  always_comb begin
    case (ofs)
      OFS_TCNT: rmux = 32'(tcnt_q);
      OFS_ICNT: rmux = 32'(commit_q);
      OFS_CTRL: rmux = 32'(ctrl_q);
      OFS_STAT: rmux = 32'(status_q);
      OFS_IEN:  rmux = 32'(ien_q);
      OFS_WST:  rmux = 32'(wst_q);
      default:  rmux = '0;
    endcase
  end

  assign rdata_o  = rd ? rmux : '0;
  assign tcnt_o   = tcnt_q;
  assign commit_o = commit_q;
  assign load_o   = load_q;
  assign ctrl_o   = ctrl_q;
  assign status_o = status_q;
  assign ien_o    = ien_q;

  // R4: a count write without the update bit leaves the commit untouched
  a_r4_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_icnt && !wdata_i[UPD_BIT]) |=> $stable(commit_q));

  // R4: update bit never reads back
  a_r4_rd_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && ofs == OFS_ICNT) |-> !rdata_o[UPD_BIT]);

  // R7: expiry always leaves status set
  a_r7_stat_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> status_q);

  // R9: reload write leaves its write-status flag set
  a_r9_wst_tcnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tcnt |=> wst_q[WST_TCNT]);

  // R2: foreign addresses read as zero
  a_r2_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rdata_o == '0));

endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned INST_ID = 0,
  parameter int unsigned TICK_W  = 32,
  parameter int unsigned ICNT_W  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);

  logic [TICK_W-1:0] tcnt;
  logic [ICNT_W-1:0] commit;
  logic              load, tick, expire, status, ien;
  ctrl_t             ctrl;

  tick_regs #(
    .ADDR_W (ADDR_W),
    .INST_ID(INST_ID),
    .TICK_W (TICK_W),
    .ICNT_W (ICNT_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .expire_i(expire),
    .tcnt_o  (tcnt),
    .commit_o(commit),
    .load_o  (load),
    .ctrl_o  (ctrl),
    .status_o(status),
    .ien_o   (ien)
  );

  tick_prescaler #(.TICK_W(TICK_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (ctrl.tick_run),
    .reload_i(tcnt),
    .tick_o  (tick)
  );

  int_counter #(.ICNT_W(ICNT_W)) u_icnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .run_i     (ctrl.int_run),
    .interval_i(ctrl.interval),
    .load_i    (load),
    .commit_i  (commit),
    .expire_o  (expire)
  );

  assign irq_o = status && ien;

  // R10: no expiry while the prescaler is halted
  a_r10_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.tick_run |-> !expire);

  // R8: an enabled expiry raises the line on the next clock
  a_r8_irq_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ien) |=> irq_o);

endmodule

// File: tb/core_tick_timer_test.sv
module core_tick_timer_test;

  localparam logic [11:0] B = 12'h300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  core_tick_timer uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic wait_irq(input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (irq) begin k = i; break; end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(B + 12'h00, d); chk("R1 tcnt", d, 0);
    rd(B + 12'h08, d); chk("R1 icnt", d, 0);
    rd(B + 12'h20, d); chk("R1 ctrl", d, 0);
    rd(B + 12'h30, d); chk("R1 stat", d, 0);
    rd(B + 12'h34, d); chk("R1 ien",  d, 0);
    rd(B + 12'h40, d); chk("R1 wst",  d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(B + 12'h00, 32'h1234_5678);
    rd(B + 12'h00, d); chk("R2 own window", d, 32'h1234_5678);
    wr(12'h400, 32'hFFFF_FFFF);
    rd(B + 12'h00, d); chk("R2 foreign write ignored", d, 32'h1234_5678);
    rd(12'h400, d);    chk("R2 foreign read zero", d, 0);
  endtask

  task automatic t_icnt;
    logic [31:0] d;
    wr(B + 12'h08, 32'h8000_0005);
    rd(B + 12'h08, d); chk("R4 commit, msb reads 0", d, 32'h0000_0005);
    wr(B + 12'h08, 32'h0000_0009);
    rd(B + 12'h08, d); chk("R4 no update bit ignored", d, 32'h0000_0005);
  endtask

  task automatic t_wstat;
    logic [31:0] d;
    wr(B + 12'h40, 32'hF);
    rd(B + 12'h40, d); chk("R9 cleared", d, 0);
    wr(B + 12'h00, 32'd7);
    rd(B + 12'h40, d); chk("R9 tcnt flag", d, 32'h1);
    wr(B + 12'h08, 32'h8000_0002);
    rd(B + 12'h40, d); chk("R9 icnt flag", d, 32'h3);
    wr(B + 12'h20, 32'h0);
    rd(B + 12'h40, d); chk("R9 ctrl flag", d, 32'hB);
    wr(B + 12'h40, 32'h2);
    rd(B + 12'h40, d); chk("R9 w1c single bit", d, 32'h9);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    int k;
    wr(B + 12'h00, 32'd1);
    wr(B + 12'h08, 32'h8000_0004);
    wr(B + 12'h34, 32'd1);
    wr(B + 12'h20, 32'h3);
    wait_irq(40, k);
    chk("R3 first expiry M*(N+1)", 32'(k), 32'd8);
    wr(B + 12'h34, 32'd0);
    chk("R8 irq masked", 32'(irq), 0);
    rd(B + 12'h30, d); chk("R8 status kept while masked", d, 1);
    wr(B + 12'h34, 32'd1);
    chk("R8 irq unmasked", 32'(irq), 1);
    wr(B + 12'h30, 32'd0);
    rd(B + 12'h30, d); chk("R7 write 0 keeps status", d, 1);
    wr(B + 12'h30, 32'd1);
    rd(B + 12'h30, d); chk("R7 write 1 clears", d, 0);
    idle(40);
    chk("R5 one-shot silent irq", 32'(irq), 0);
    rd(B + 12'h30, d); chk("R5 one-shot silent status", d, 0);
    wr(B + 12'h20, 32'h0);
  endtask

  task automatic t_interval;
    logic [31:0] d;
    int hits [3];
    int nh;
    nh = 0;
    wr(B + 12'h00, 32'd2);
    wr(B + 12'h08, 32'h8000_0003);
    wr(B + 12'h34, 32'd1);
    wr(B + 12'h20, 32'h7);
    for (int i = 1; i <= 30; i++) begin
      @(posedge clk);
      #1 req = 1'b0; we = 1'b0;
      @(negedge clk);
      if (irq) begin
        if (nh < 3) hits[nh] = i;
        nh++;
        req = 1'b1; we = 1'b1; addr = B + 12'h30; wdata = 32'd1;
      end
    end
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
    chk("R6 firing count", 32'(nh), 3);
    chk("R6 first", 32'(hits[0]), 9);
    chk("R6 second", 32'(hits[1]), 18);
    chk("R6 third", 32'(hits[2]), 27);
    wr(B + 12'h20, 32'h0);
    wr(B + 12'h30, 32'd1);
    idle(40);
    rd(B + 12'h30, d); chk("R10 halted no status", d, 0);
    chk("R10 halted no irq", 32'(irq), 0);
  endtask

  task automatic t_fast;
    int k;
    wr(B + 12'h00, 32'd0);
    wr(B + 12'h08, 32'h8000_0005);
    wr(B + 12'h34, 32'd1);
    wr(B + 12'h20, 32'h3);
    wait_irq(40, k);
    chk("R11 reload 0 period M", 32'(k), 32'd5);
    wr(B + 12'h20, 32'h0);
    wr(B + 12'h30, 32'd1);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_decode;
    t_icnt;
    t_wstat;
    t_oneshot;
    t_interval;
    t_fast;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule